// File: doc/BRIEF.md
# Matrix remap index generator

This block turns the linear step count of a vector loop into a reshaped element index. A 32-bit shape word describes up to three nested axes, each with its own size. It also picks the nesting order of those axes and can reverse any of them. One axis may be dropped from the index, and a small constant is added at the end. Transposition, mirroring, repeated runs (0 0 0 1 1 1 ...) and modulo runs (0 1 2 0 1 2 ...) all come from one descriptor without unrolling the loop.

A caller presents the shape word and a vector length, then pulses `start_i`. The generator then holds the index for step 0 on `idx_o` with `valid_o` high. Each `step_i` pulse moves it to the next step. `done_o` marks the last step of the run, and the next pulse after it ends the run. A shape word that does not select matrix reshaping passes the step number straight through.

Top module: `matrix_remap_gen`

## Requirements
- R1: The shape word is decoded as x size-1 in bits 5:0, y size-1 in bits 11:6, z size-1 in bits 17:12, loop order in bits 20:18, reverse flags in bits 23:21 (bit 21 = x, 22 = y, 23 = z), offset in bits 27:24, skip code in bits 29:28 and mode in bits 31:30; mode 0 with loop order 0 to 5 selects matrix reshaping.
- R2: A `start_i` pulse with `vl_i` nonzero raises `valid_o` in the next cycle with step 0 presented. With `vl_i` = 0 it leaves `valid_o` low.
- R3: While `valid_o` is high and neither `step_i` nor `start_i` is asserted, `idx_o` and `valid_o` hold their values.
- R4: Axes are nested in the order picked by the loop-order field, innermost first: 0 = x,y,z; 1 = x,z,y; 2 = y,x,z; 3 = y,z,x; 4 = z,x,y; 5 = z,y,x. The innermost axis advances every step and carries into the next one on wrap, and the outermost wraps to 0.
- R5: An axis whose reverse flag is set runs from its size minus 1 down to 0 instead of from 0 up.
- R6: Skip code 1, 2 or 3 drops the x, y or z axis from the index; code 0 keeps all. The index is the mixed-radix sum of the kept axes, each weighted by the product of the sizes of the kept axes nested inside it.
- R7: The offset field is added to every matrix index.
- R8: An all-zero shape word, a nonzero mode, or loop order 6 or 7 makes `idx_o` equal to the step number.
- R9: `done_o` is high exactly while step `vl_i`-1 is presented. A `step_i` pulse in that state drops `valid_o` and `done_o` in the next cycle.
- R10: A `start_i` pulse during a run restarts at step 0 with the new shape word and length. `start_i` takes priority over `step_i`.
- R11: `step_i` while no run is active has no effect, and `valid_o` stays low.
- R12: While `rst_ni` is low, and after it rises, `valid_o` and `done_o` are low until the first start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Latch shape and length, begin at step 0 |
| step_i | input | 1 | Advance to the next step |
| shape_i | input | 32 | Shape descriptor |
| vl_i | input | 7 | Number of steps in the run (0 to 127) |
| idx_o | output | 19 | Remapped element index of the current step |
| valid_o | output | 1 | A step is being presented |
| done_o | output | 1 | The presented step is the last one |

## Verification
The bench builds the block with its default parameters: 6-bit axis fields, a 4-bit offset and a 7-bit step count. With these, runs of 127 steps are reachable and the outer axes wrap several times within one run. Axes of up to 64 elements, and every combination of loop order, reverse flags and skip code, can be reached from one shape word. Random shapes draw mostly small axes, so that carries and full wraps appear often within short runs. Directed shapes cover the pass-through encodings, a length of 1 and 0, and a restart in mid-run.

// File: rtl/matrix_remap_pkg.sv
`timescale 1ns/1ps
package matrix_remap_pkg;

  localparam int unsigned NUM_AXES = 3;
  localparam int unsigned ORD_W    = 3;
  localparam int unsigned SKIP_W   = 2;
  localparam int unsigned MODE_W   = 2;

  typedef logic [1:0] axis_t;
  typedef axis_t [NUM_AXES-1:0] order_t;  // [0] = innermost

  function automatic order_t perm_order(input logic [ORD_W-1:0] p);
    order_t o;
    case (p)
      3'd1:    begin o[0] = 2'd0; o[1] = 2'd2; o[2] = 2'd1; end
      3'd2:    begin o[0] = 2'd1; o[1] = 2'd0; o[2] = 2'd2; end
      3'd3:    begin o[0] = 2'd1; o[1] = 2'd2; o[2] = 2'd0; end
      3'd4:    begin o[0] = 2'd2; o[1] = 2'd0; o[2] = 2'd1; end
      3'd5:    begin o[0] = 2'd2; o[1] = 2'd1; o[2] = 2'd0; end
      default: begin o[0] = 2'd0; o[1] = 2'd1; o[2] = 2'd2; end
    endcase
    return o;
  endfunction

endpackage

// File: rtl/matrix_remap_axes.sv
`timescale 1ns/1ps
module matrix_remap_axes
  import matrix_remap_pkg::*;
#(
  parameter int unsigned DIM_W = 6
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               clear_i,
  input  logic                               adv_i,
  input  logic [NUM_AXES-1:0][DIM_W-1:0]     size_m1_i,
  input  order_t                             order_i,
  output logic [NUM_AXES-1:0][DIM_W-1:0]     cnt_o
);

  logic [NUM_AXES-1:0][DIM_W-1:0] cnt_q;
  logic [NUM_AXES-1:0]            at_max;
  logic [NUM_AXES-1:0]            inc;
  logic [NUM_AXES:0]              carry;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_max
    assign at_max[a] = (cnt_q[a] == size_m1_i[a]);
  end

  // ripple carry through axes in nesting order
  always_comb begin
    inc      = '0;
    carry[0] = adv_i;
    for (int k = 0; k < NUM_AXES; k++) begin
      inc[order_i[k]] = carry[k];
      carry[k+1]      = carry[k] & at_max[order_i[k]];
    end
  end

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q[a] <= '0;
      else if (clear_i)  cnt_q[a] <= '0;
      else if (inc[a])   cnt_q[a] <= at_max[a] ? '0 : cnt_q[a] + DIM_W'(1);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/matrix_remap_combine.sv
`timescale 1ns/1ps
module matrix_remap_combine
  import matrix_remap_pkg::*;
#(
  parameter int unsigned DIM_W  = 6,
  parameter int unsigned OFS_W  = 4,
  parameter int unsigned STEP_W = 7,
  parameter int unsigned IDX_W  = 3*DIM_W+1
) (
  input  logic [NUM_AXES-1:0][DIM_W-1:0] cnt_i,
  input  logic [NUM_AXES-1:0][DIM_W-1:0] size_m1_i,
  input  order_t                         order_i,
  input  logic [NUM_AXES-1:0]            rev_i,
  input  logic [SKIP_W-1:0]              skip_i,
  input  logic [OFS_W-1:0]               offset_i,
  input  logic                           bypass_i,
  input  logic [STEP_W-1:0]              step_i,
  output logic [IDX_W-1:0]               idx_o
);

  localparam int unsigned SIZE_W = DIM_W + 1;

  logic [NUM_AXES-1:0][DIM_W-1:0]  eff;
  logic [NUM_AXES-1:0][SIZE_W-1:0] size;
  logic [NUM_AXES-1:0]             keep;
  logic [IDX_W-1:0]                acc, wgt, term;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    assign eff[a]  = rev_i[a] ? (size_m1_i[a] - cnt_i[a]) : cnt_i[a];
    assign size[a] = SIZE_W'(size_m1_i[a]) + SIZE_W'(1);
    assign keep[a] = (skip_i != SKIP_W'(a + 1));
  end

  // mixed-radix sum over kept axes, inner to outer
  always_comb begin
    acc = '0;
    wgt = IDX_W'(1);
    for (int k = 0; k < NUM_AXES; k++) begin
      term = IDX_W'(eff[order_i[k]]) * wgt;
      if (keep[order_i[k]]) begin
        acc = acc + term;
        wgt = wgt * IDX_W'(size[order_i[k]]);
      end
    end
  end

  assign idx_o = bypass_i ? IDX_W'(step_i) : acc + IDX_W'(offset_i);

endmodule

// File: rtl/matrix_remap_gen.sv
`timescale 1ns/1ps
module matrix_remap_gen
  import matrix_remap_pkg::*;
#(
  parameter  int unsigned DIM_W   = 6,
  parameter  int unsigned OFS_W   = 4,
  parameter  int unsigned STEP_W  = 7,
  localparam int unsigned SHAPE_W = NUM_AXES*DIM_W + ORD_W + NUM_AXES + OFS_W + SKIP_W + MODE_W,
  localparam int unsigned IDX_W   = NUM_AXES*DIM_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               step_i,
  input  logic [SHAPE_W-1:0] shape_i,
  input  logic [STEP_W-1:0]  vl_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               valid_o,
  output logic               done_o
);

  localparam int unsigned ORD_LO  = NUM_AXES*DIM_W;
  localparam int unsigned REV_LO  = ORD_LO + ORD_W;
  localparam int unsigned OFS_LO  = REV_LO + NUM_AXES;
  localparam int unsigned SKIP_LO = OFS_LO + OFS_W;
  localparam int unsigned MODE_LO = SKIP_LO + SKIP_W;

  logic [SHAPE_W-1:0]             shape_q;
  logic [STEP_W-1:0]              vl_q, step_q;
  logic                           run_q;
  logic                           last, adv;
  logic [NUM_AXES-1:0][DIM_W-1:0] size_m1, cnt;
  logic [ORD_W-1:0]               perm;
  order_t                         order;
  logic                           bypass;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_dec
    assign size_m1[a] = shape_q[a*DIM_W +: DIM_W];
  end

  assign perm   = shape_q[ORD_LO +: ORD_W];
  assign order  = perm_order(perm);
  assign bypass = (shape_q == '0) || (shape_q[MODE_LO +: MODE_W] != '0) || (perm > ORD_W'(5));

  assign last = run_q && (step_q == vl_q - STEP_W'(1));
  assign adv  = run_q && step_i && !start_i && !last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shape_q <= '0;
      vl_q    <= '0;
      step_q  <= '0;
      run_q   <= 1'b0;
    end else if (start_i) begin
      shape_q <= shape_i;
      vl_q    <= vl_i;
      step_q  <= '0;
      run_q   <= (vl_i != '0);
    end else if (run_q && step_i) begin
      if (last) run_q  <= 1'b0;
      else      step_q <= step_q + STEP_W'(1);
    end
  end

  matrix_remap_axes #(.DIM_W(DIM_W)) u_axes (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_i),
    .adv_i     (adv),
    .size_m1_i (size_m1),
    .order_i   (order),
    .cnt_o     (cnt)
  );

  matrix_remap_combine #(
    .DIM_W (DIM_W),
    .OFS_W (OFS_W),
    .STEP_W(STEP_W),
    .IDX_W (IDX_W)
  ) u_comb (
    .cnt_i     (cnt),
    .size_m1_i (size_m1),
    .order_i   (order),
    .rev_i     (shape_q[REV_LO +: NUM_AXES]),
    .skip_i    (shape_q[SKIP_LO +: SKIP_W]),
    .offset_i  (shape_q[OFS_LO +: OFS_W]),
    .bypass_i  (bypass),
    .step_i    (step_q),
    .idx_o     (idx_o)
  );

  assign valid_o = run_q;
  assign done_o  = last;

endmodule

// File: rtl/matrix_remap_chk.sv
`timescale 1ns/1ps
module matrix_remap_chk #(
  parameter int unsigned DIM_W   = 6,
  parameter int unsigned SHAPE_W = 32,
  parameter int unsigned STEP_W  = 7,
  parameter int unsigned IDX_W   = 19
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               step_i,
  input logic [SHAPE_W-1:0] shape_i,
  input logic [STEP_W-1:0]  vl_i,
  input logic [IDX_W-1:0]   idx_o,
  input logic               valid_o,
  input logic               done_o
);

  logic              byp_q;
  logic [STEP_W-1:0] vl_q, cnt_q;
  logic [2:0]        perm;

  assign perm = shape_i[3*DIM_W +: 3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q <= 1'b0;
      vl_q  <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      byp_q <= (shape_i == '0) || (shape_i[SHAPE_W-1 -: 2] != 2'b00) || (perm > 3'd5);
      vl_q  <= vl_i;
      cnt_q <= '0;
    end else if (step_i && valid_o) begin
      cnt_q <= cnt_q + STEP_W'(1);
    end
  end

  assert_start_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (vl_i != '0) |=> valid_o);

  assert_start_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (vl_i == '0) |=> !valid_o);

  assert_hold_idx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !step_i && !start_i |=> valid_o && $stable(idx_o));

  assert_pass_through_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && byp_q |-> idx_o == IDX_W'(cnt_q));

  assert_done_pos_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> done_o == (cnt_q == vl_q - STEP_W'(1)));

  assert_done_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && step_i && !start_i |=> !valid_o && !done_o);

  assert_idle_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && !start_i |=> !valid_o && !done_o);

  assert_done_valid_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);

endmodule

bind matrix_remap_gen matrix_remap_chk #(
  .DIM_W  (DIM_W),
  .SHAPE_W(SHAPE_W),
  .STEP_W (STEP_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .step_i (step_i),
  .shape_i(shape_i),
  .vl_i   (vl_i),
  .idx_o  (idx_o),
  .valid_o(valid_o),
  .done_o (done_o)
);

// File: tb/matrix_remap_gen_bench.sv
`timescale 1ns/1ps
module matrix_remap_gen_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        step_i = 1'b0;
  logic [31:0] shape_i = '0;
  logic [6:0]  vl_i = '0;
  logic [18:0] idx_o;
  logic        valid_o, done_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  matrix_remap_gen u_matrix_remap_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .step_i (step_i),
    .shape_i(shape_i),
    .vl_i   (vl_i),
    .idx_o  (idx_o),
    .valid_o(valid_o),
    .done_o (done_o)
  );

  function automatic logic [31:0] mk(int x, int y, int z, int ord, int rev, int ofs, int skp, int md);
    return {md[1:0], skp[1:0], ofs[3:0], rev[2:0], ord[2:0], z[5:0], y[5:0], x[5:0]};
  endfunction

  // reference index from the requirements (R1, R4-R8)
  function automatic int ref_idx(logic [31:0] sh, int step);
    int sz[3], c[3], o[3];
    int rem, idx, w, e, prm, skp;
    prm = int'(sh[20:18]);
    if (sh == 0 || sh[31:30] != 0 || prm > 5) return step;
    sz[0] = int'(sh[5:0]) + 1;
    sz[1] = int'(sh[11:6]) + 1;
    sz[2] = int'(sh[17:12]) + 1;
    case (prm)
      1: o = '{0, 2, 1};
      2: o = '{1, 0, 2};
      3: o = '{1, 2, 0};
      4: o = '{2, 0, 1};
      5: o = '{2, 1, 0};
      default: o = '{0, 1, 2};
    endcase
    rem = step % (sz[0] * sz[1] * sz[2]);
    for (int k = 0; k < 3; k++) begin
      c[o[k]] = rem % sz[o[k]];
      rem     = rem / sz[o[k]];
    end
    skp = int'(sh[29:28]);
    idx = 0;
    w   = 1;
    for (int k = 0; k < 3; k++) begin
      e = sh[21 + o[k]] ? sz[o[k]] - 1 - c[o[k]] : c[o[k]];
      if (skp != o[k] + 1) begin
        idx = idx + e * w;
        w   = w * sz[o[k]];
      end
    end
    return idx + int'(sh[27:24]);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic begin_run(logic [31:0] sh, int vl);
    @(negedge clk_i);
    shape_i = sh;
    vl_i    = 7'(vl);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic do_step();
    step_i = 1'b1;
    @(negedge clk_i);
    step_i = 1'b0;
  endtask

  task automatic run_case(logic [31:0] sh, int vl, string req);
    int exp;
    begin_run(sh, vl);
    if (vl == 0) begin
      check(!valid_o && !done_o, "R2", "empty run valid", int'(valid_o), 0);
      return;
    end
    for (int k = 0; k < vl; k++) begin
      exp = ref_idx(sh, k);
      check(valid_o && idx_o == 19'(exp), req, "idx", int'(idx_o), exp);
      check(done_o == (k == vl - 1), "R9", "done", int'(done_o), int'(k == vl - 1));
      do_step();
    end
    check(!valid_o && !done_o, "R9", "run end valid", int'(valid_o), 0);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog actual hung expected finished");
    finish_up();
  end

  initial begin
    int exp;
    void'($urandom(32'h0c0ffee5));
    repeat (2) @(negedge clk_i);
    check(!valid_o && !done_o, "R12", "in reset", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!valid_o && !done_o, "R12", "after reset", int'(valid_o), 0);

    // R11: step while idle
    do_step();
    do_step();
    check(!valid_o && !done_o, "R11", "idle step", int'(valid_o), 0);

    // R8: pass-through encodings
    run_case(32'h0, 10, "R8");
    run_case(mk(2, 1, 0, 0, 0, 3, 0, 1), 7, "R8");
    run_case(mk(2, 1, 0, 6, 0, 0, 0, 0), 5, "R8");
    run_case(mk(3, 3, 0, 7, 0, 0, 0, 0), 5, "R8");

    // R4: each loop order, uneven sizes
    for (int p = 0; p < 6; p++) run_case(mk(2, 1, 3, p, 0, 0, 0, 0), 24, "R4");
    // R4: run longer than the shape wraps the outermost axis
    run_case(mk(1, 1, 0, 0, 0, 0, 0, 0), 10, "R4");

    // R5: reversal, single and mixed
    run_case(mk(3, 0, 0, 0, 1, 0, 0, 0), 8, "R5");
    run_case(mk(2, 1, 2, 3, 5, 0, 0, 0), 18, "R5");
    run_case(mk(1, 2, 1, 5, 7, 0, 0, 0), 12, "R5");

    // R6: skip codes; skip x on 3x3 gives 0 0 0 1 1 1 2 2 2
    begin_run(mk(2, 2, 0, 0, 0, 0, 1, 0), 9);
    for (int k = 0; k < 9; k++) begin
      check(valid_o && idx_o == 19'(k / 3), "R6", "skip x literal", int'(idx_o), k / 3);
      do_step();
    end
    for (int s = 1; s < 4; s++) run_case(mk(2, 1, 2, 1, 0, 0, s, 0), 18, "R6");

    // R7: offset
    run_case(mk(2, 2, 0, 2, 0, 9, 0, 0), 9, "R7");
    run_case(mk(1, 0, 1, 4, 2, 15, 3, 0), 8, "R7");

    // R9: single-step run, full-length run with large axes
    run_case(mk(4, 4, 4, 0, 0, 0, 0, 0), 1, "R9");
    run_case(mk(63, 63, 63, 3, 7, 15, 0, 0), 127, "R4");
    run_case(mk(5, 6, 2, 2, 3, 1, 2, 0), 0, "R2");

    // R3: hold without step
    begin_run(mk(2, 3, 1, 1, 2, 4, 0, 0), 20);
    do_step();
    exp = ref_idx(mk(2, 3, 1, 1, 2, 4, 0, 0), 1);
    repeat (3) @(negedge clk_i);
    check(valid_o && idx_o == 19'(exp), "R3", "hold", int'(idx_o), exp);

    // R10: restart in mid-run, start wins over step
    do_step();
    do_step();
    @(negedge clk_i);
    shape_i = mk(3, 2, 0, 2, 1, 5, 0, 0);
    vl_i    = 7'd12;
    start_i = 1'b1;
    step_i  = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    step_i  = 1'b0;
    exp = ref_idx(mk(3, 2, 0, 2, 1, 5, 0, 0), 0);
    check(valid_o && idx_o == 19'(exp), "R10", "restart step0", int'(idx_o), exp);
    run_case(mk(3, 2, 0, 2, 1, 5, 0, 0), 12, "R10");

    // R1: random shapes
    for (int n = 0; n < 40; n++) begin
      int x, y, z;
      x = (n % 8 == 0) ? int'($urandom_range(0, 63)) : int'($urandom_range(0, 5));
      y = int'($urandom_range(0, 5));
      z = int'($urandom_range(0, 4));
      run_case(mk(x, y, z, int'($urandom_range(0, 5)), int'($urandom_range(0, 7)),
                  int'($urandom_range(0, 15)), int'($urandom_range(0, 3)), 0),
               int'($urandom_range(1, 127)), "R1");
    end

    repeat (2) @(negedge clk_i);
    finish_up();
  end

endmodule